// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A requester presents a virtual address together with the kind of access it wants: read, write or execute. The walker splits the address into a 12-bit top index, a 10-bit lower index and a 10-bit page offset. It reads one first-level entry and then one second-level entry through a single-outstanding memory port. It then returns either the physical address or a fault code.

The leaf entry is checked for presence and for the permission that matches the access. When the access is allowed and the leaf's referenced flag is clear, the entry is written back with that flag set. The same write-back happens when the access is a write and the dirty flag is clear, and the dirty flag is then set as well. The write-back is acknowledged before completion is signalled. The first-level table base comes from a register outside the block and is presented on an input. Only one translation runs at a time.

Top module: `ptw_top`

## Requirements
- R1: The first memory read of a walk is at `base_addr + 4 * vaddr[31:20]`.
- R2: A valid first-level entry leads to a second read at `(entry[31:10] << 10) + 4 * vaddr[19:10]`, which is exactly two reads per walk. Entry bit layout: bit 0 valid, bit 1 read-allowed, bit 2 write-allowed, bit 3 execute-allowed, bit 4 referenced, bit 5 dirty, bits 31:10 frame number.
- R3: On success `done` pulses and `paddr = {leaf[31:10], vaddr[9:0]}`.
- R4: A first-level entry with bit 0 clear ends the walk after one read, with `fault` and `fault_code = 1`.
- R5: A leaf with bit 0 clear ends the walk with `fault_code = 2` and writes nothing.
- R6: `req_acc` is encoded 0 read, 1 write, 2 execute, 3 reserved. A leaf whose matching permission bit is clear, or a request with code 3, ends the walk with `fault_code = 3` and writes nothing.
- R7: On success with the referenced bit clear, or on a write with the dirty bit clear, the leaf is written back once to its own address with bit 4 set, and with bit 5 set on a write. All other bits are kept. Otherwise no write is issued.
- R8: When a write-back is issued, `done` is not raised before the memory acknowledges that write.
- R9: `busy` is high from the cycle after acceptance through the `done`/`fault` cycle. `req_valid` is ignored while `busy` is high.
- R10: `done` and `fault` are single-cycle pulses and never high together.
- R11: After reset `busy`, `done`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | 32 | Physical address of the first-level table |
| req_valid | input | 1 | Start a translation (taken when busy is low) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value for write-back |
| mem_rvalid | input | 1 | Response or write acknowledge, one per request |
| mem_rdata | input | 32 | Read data with the response |
| done | output | 1 | Translation succeeded (one cycle) |
| paddr | output | 32 | Translated physical address |
| fault | output | 1 | Translation failed (one cycle) |
| fault_code | output | 2 | 1 first level absent, 2 leaf absent, 3 permission |

## Verification
The hardest situation to reach from the ports is a second request arriving in the middle of a walk, while the memory is slow enough that the walker is parked waiting for a response. The bench gives the memory model a multi-cycle latency and pulses `req_valid` with a different address during that wait. It then checks that the result, the read addresses and the read count all belong to the first request only. A second hard case is telling apart the write-back cases where the flags are already set from those where they are not, because both end in `done`. The bench reaches this by presetting the leaf flags, and it checks the write count and the stored entry.

// File: rtl/ptw_pkg.sv
// Package: shared constants and types of the page table walker.
// Assumes 32-bit entries whose flag bits sit below the frame number field.
package ptw_pkg;
    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 10;
    localparam int L1_BITS   = 12;
    localparam int ENTRY_B   = 4;

    localparam int B_VALID = 0;
    localparam int B_RD    = 1;
    localparam int B_WR    = 2;
    localparam int B_EX    = 3;
    localparam int B_REF   = 4;
    localparam int B_DIRTY = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_L1_NP = 2'd1,
        FLT_L2_NP = 2'd2,
        FLT_PROT  = 2'd3
    } flt_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT,
        ST_WB_REQ, ST_WB_WAIT, ST_DONE, ST_FAULT
    } walk_st_e;
endpackage

// File: rtl/ptw_addr_split.sv
// Module: splits the latched virtual address into table indices and forms
// both entry addresses. Purely combinational; assumes the indices fill the
// part of the address above the page offset.
module ptw_addr_split #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 10,
    parameter int L1_BITS   = 12,
    parameter int ENTRY_B   = 4
) (
    input  logic [ADDR_W-1:0]           vaddr,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ADDR_W-PAGE_BITS-1:0] table_frame,
    output logic [ADDR_W-1:0]           l1_addr,
    output logic [ADDR_W-1:0]           l2_addr
);
    localparam int L2_BITS = ADDR_W - PAGE_BITS - L1_BITS;
    localparam int E_SHIFT = $clog2(ENTRY_B);

    logic [L1_BITS-1:0] idx_top;
    logic [L2_BITS-1:0] idx_low;

    // Index extraction from the page number.
    always_comb begin
        idx_top = vaddr[ADDR_W-1 -: L1_BITS];
        idx_low = vaddr[PAGE_BITS +: L2_BITS];
    end

    // Entry address arithmetic for both levels.
    always_comb begin
        l1_addr = base + (ADDR_W'(idx_top) << E_SHIFT);
        l2_addr = {table_frame, {PAGE_BITS{1'b0}}} + (ADDR_W'(idx_low) << E_SHIFT);
    end
endmodule

// File: rtl/ptw_perm_check.sv
// Module: decides whether a leaf entry permits the access and computes the
// entry value with updated referenced/dirty flags. Combinational; the
// caller looks at it only in the cycle the leaf arrives.
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output logic             allowed,
    output logic             need_wb,
    output logic [PTE_W-1:0] pte_upd
);
    // Permission selection by access kind; the reserved code is never allowed.
    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = pte[B_RD];
            ACC_WRITE: allowed = pte[B_WR];
            ACC_EXEC:  allowed = pte[B_EX];
            default:   allowed = 1'b0;
        endcase
    end

    // Flag update and the decision whether a write-back is needed.
    always_comb begin
        pte_upd         = pte;
        pte_upd[B_REF]  = 1'b1;
        if (acc == ACC_WRITE) begin
            pte_upd[B_DIRTY] = 1'b1;
        end
        need_wb = (pte_upd != pte);
    end
endmodule

// File: rtl/ptw_walk_fsm.sv
// Module: sequences one walk (first read, second read, optional write-back)
// and produces the single-cycle done/fault result. Assumes the memory
// answers each request with exactly one mem_rvalid, at least one cycle later.
module ptw_walk_fsm
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_vaddr,
    input  logic [1:0]                  req_acc,
    input  logic [ADDR_W-1:0]           l1_addr,
    input  logic [ADDR_W-1:0]           l2_addr,
    input  logic                        allowed,
    input  logic                        need_wb,
    input  logic [ADDR_W-1:0]           pte_upd,
    input  logic                        mem_rvalid,
    input  logic [ADDR_W-1:0]           mem_rdata,
    output logic [ADDR_W-1:0]           vaddr_q,
    output logic [1:0]                  acc_q,
    output logic [ADDR_W-PAGE_BITS-1:0] frame_q,
    output logic                        busy,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [ADDR_W-1:0]           mem_wdata,
    output logic                        done,
    output logic [ADDR_W-1:0]           paddr,
    output logic                        fault,
    output logic [1:0]                  fault_code
);
    walk_st_e          st_q, st_d;
    logic [ADDR_W-1:0] wb_q;
    logic [1:0]        code_q;

    // Next-state selection for the walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (req_valid) st_d = ST_L1_REQ;
            ST_L1_REQ:  st_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rvalid) st_d = mem_rdata[B_VALID] ? ST_L2_REQ : ST_FAULT;
            ST_L2_REQ:  st_d = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rvalid) begin
                    if (!mem_rdata[B_VALID] || !allowed) st_d = ST_FAULT;
                    else if (need_wb)                    st_d = ST_WB_REQ;
                    else                                 st_d = ST_DONE;
                end
            end
            ST_WB_REQ:  st_d = ST_WB_WAIT;
            ST_WB_WAIT: if (mem_rvalid) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            ST_FAULT:   st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            acc_q   <= '0;
        end else if (st_q == ST_IDLE && req_valid) begin
            vaddr_q <= req_vaddr;
            acc_q   <= req_acc;
        end
    end

    // Capture of first-level table frame, leaf result and fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            wb_q    <= '0;
            paddr   <= '0;
            code_q  <= FLT_NONE;
        end else if (mem_rvalid && st_q == ST_L1_WAIT) begin
            frame_q <= mem_rdata[ADDR_W-1:PAGE_BITS];
            if (!mem_rdata[B_VALID]) code_q <= FLT_L1_NP;
        end else if (mem_rvalid && st_q == ST_L2_WAIT) begin
            wb_q  <= pte_upd;
            paddr <= {mem_rdata[ADDR_W-1:PAGE_BITS], vaddr_q[PAGE_BITS-1:0]};
            if (!mem_rdata[B_VALID]) code_q <= FLT_L2_NP;
            else if (!allowed)       code_q <= FLT_PROT;
        end
    end

    // Port outputs decoded from the state.
    always_comb begin
        busy       = (st_q != ST_IDLE);
        mem_req    = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ) || (st_q == ST_WB_REQ);
        mem_we     = (st_q == ST_WB_REQ);
        mem_addr   = (st_q == ST_L1_REQ) ? l1_addr : (mem_req ? l2_addr : '0);
        mem_wdata  = mem_we ? wb_q : '0;
        done       = (st_q == ST_DONE);
        fault      = (st_q == ST_FAULT);
        fault_code = fault ? code_q : FLT_NONE;
    end

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    p_mem_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    p_fault_coded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != FLT_NONE));
    p_wb_sets_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[B_REF] && mem_wdata[B_VALID]));
    p_paddr_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (paddr[PAGE_BITS-1:0] == vaddr_q[PAGE_BITS-1:0]));
    p_wb_acked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WB_WAIT && !mem_rvalid) |=> !done);
endmodule

// File: rtl/ptw_top.sv
// Module: two-level page table walker top. Joins the address split, the
// permission/flag logic and the walk sequencer. Assumes base_addr stays
// stable while a walk is in progress.
module ptw_top
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] base_addr,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_acc,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] paddr,
    output logic        fault,
    output logic [1:0]  fault_code
);
    localparam int FRAME_W = ADDR_W - PAGE_BITS;

    logic [ADDR_W-1:0]  vaddr_q;
    logic [1:0]         acc_q;
    logic [FRAME_W-1:0] frame_q;
    logic [ADDR_W-1:0]  l1_addr, l2_addr, pte_upd;
    logic               allowed, need_wb;

    ptw_addr_split #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .L1_BITS(L1_BITS), .ENTRY_B(ENTRY_B)
    ) u_split (
        .vaddr(vaddr_q), .base(base_addr), .table_frame(frame_q),
        .l1_addr(l1_addr), .l2_addr(l2_addr)
    );

    ptw_perm_check #(.PTE_W(ADDR_W)) u_perm (
        .pte(mem_rdata), .acc(acc_q), .allowed(allowed),
        .need_wb(need_wb), .pte_upd(pte_upd)
    );

    ptw_walk_fsm #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .l1_addr(l1_addr), .l2_addr(l2_addr),
        .allowed(allowed), .need_wb(need_wb), .pte_upd(pte_upd),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .vaddr_q(vaddr_q), .acc_q(acc_q), .frame_q(frame_q),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .paddr(paddr), .fault(fault), .fault_code(fault_code)
    );

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done && !fault));
endmodule

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_ptw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        busy, mem_req, mem_we, done, fault;
    logic [31:0] mem_addr, mem_wdata, paddr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault_code;

    always #2.5 clk = ~clk;

    ptw_top dut (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .paddr(paddr), .fault(fault), .fault_code(fault_code)
    );

    // Memory model: 64 KB, word addressed, one response per request.
    logic [31:0] mem [0:16383];
    int          lat = 0;
    int          n_rd = 0, n_wr = 0;
    logic [31:0] rd_log [0:63];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          cnt = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[15:2]] <= mem_wdata;
                n_wr = n_wr + 1;
            end else begin
                rd_log[n_rd % 64] <= mem_addr;
                n_rd = n_rd + 1;
            end
            pend      <= 1'b1;
            pend_addr <= mem_addr;
            cnt       <= lat;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[pend_addr[15:2]];
                pend       <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_pte(input logic [21:0] frame, input logic v, r, w, x, rf, d);
        return {frame, 4'b0, d, rf, x, w, r, v};
    endfunction

    function automatic logic [31:0] mk_va(input logic [11:0] i1, input logic [9:0] i2, input logic [9:0] off);
        return {i1, i2, off};
    endfunction

    // Result of the last walk, filled by run_walk.
    logic        r_done, r_fault;
    logic [1:0]  r_code;
    logic [31:0] r_pa;
    int          r_rd, r_wr, r_rd0;

    task automatic run_walk(input logic [31:0] va, input logic [1:0] acc, input bit intrude);
        int rd0, wr0, guard;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr; r_rd0 = n_rd;
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!(done || fault) && guard < 200) begin
            if (intrude && guard == 2) begin
                chk("R9 busy during walk", {31'b0, busy}, 32'd1);
                req_valid = 1'b1; req_vaddr = ~va; req_acc = 2'd3;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        if (guard >= 200) chk("walk timeout", 32'd0, 32'd1);
        r_done = done; r_fault = fault; r_code = fault_code; r_pa = paddr;
        chk("R9 busy in result cycle", {31'b0, busy}, 32'd1);
        chk("R10 not both", {31'b0, done && fault}, 32'd0);
        @(negedge clk);
        chk("R10 pulse done", {31'b0, done}, 32'd0);
        chk("R10 pulse fault", {31'b0, fault}, 32'd0);
        chk("R9 busy released", {31'b0, busy}, 32'd0);
        r_rd = n_rd - rd0; r_wr = n_wr - wr0;
    endtask

    task automatic t_reset();
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 done", {31'b0, done}, 32'd0);
        chk("R11 fault", {31'b0, fault}, 32'd0);
        chk("R11 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    // Successful walk with expected write-back decided by the flags.
    task automatic t_ok(input logic [31:0] base, input logic [11:0] i1, input logic [9:0] i2,
                        input logic [9:0] off, input logic [21:0] tframe, input logic [21:0] dframe,
                        input logic [1:0] acc, input logic rf, input logic d, input int l,
                        input bit intrude);
        logic [31:0] e1, e2, leaf, exp_leaf;
        bit wb;
        lat = l;
        base_addr = base;
        e1 = base + {18'b0, i1, 2'b0};
        e2 = {tframe, 10'b0} + {20'b0, i2, 2'b0};
        mem[e1[15:2]] = mk_pte(tframe, 1, 0, 0, 0, 0, 0);
        leaf = mk_pte(dframe, 1, acc == 2'd0, acc == 2'd1, acc == 2'd2, rf, d);
        mem[e2[15:2]] = leaf;
        exp_leaf = leaf; exp_leaf[4] = 1'b1;
        if (acc == 2'd1) exp_leaf[5] = 1'b1;
        wb = (exp_leaf != leaf);
        run_walk(mk_va(i1, i2, off), acc, intrude);
        chk("R3 done", {31'b0, r_done}, 32'd1);
        chk("R3 paddr", r_pa, {dframe, off});
        chk("R1 first read addr", rd_log[r_rd0 % 64], e1);
        chk("R2 second read addr", rd_log[(r_rd0 + 1) % 64], e2);
        chk("R2 read count", r_rd, 32'd2);
        chk("R7 write count", r_wr, wb ? 32'd1 : 32'd0);
        chk("R7 stored leaf", mem[e2[15:2]], exp_leaf);
    endtask

    task automatic t_l1_absent();
        logic [31:0] e1;
        lat = 1; base_addr = 32'h0;
        e1 = {18'b0, 12'd2, 2'b0};
        mem[e1[15:2]] = mk_pte(22'h20, 0, 1, 1, 1, 0, 0);
        run_walk(mk_va(12'd2, 10'd5, 10'h11), 2'd0, 0);
        chk("R4 fault", {31'b0, r_fault}, 32'd1);
        chk("R4 code", {30'b0, r_code}, 32'd1);
        chk("R4 one read", r_rd, 32'd1);
        chk("R4 no write", r_wr, 32'd0);
    endtask

    task automatic t_l2_absent();
        logic [31:0] e1, e2, leaf;
        lat = 0; base_addr = 32'h0;
        e1 = {18'b0, 12'd4, 2'b0};
        e2 = {22'h24, 10'b0} + {20'b0, 10'd9, 2'b0};
        mem[e1[15:2]] = mk_pte(22'h24, 1, 0, 0, 0, 0, 0);
        leaf = mk_pte(22'h777, 0, 1, 1, 1, 0, 0);
        mem[e2[15:2]] = leaf;
        run_walk(mk_va(12'd4, 10'd9, 10'h3), 2'd1, 0);
        chk("R5 fault", {31'b0, r_fault}, 32'd1);
        chk("R5 code", {30'b0, r_code}, 32'd2);
        chk("R5 two reads", r_rd, 32'd2);
        chk("R5 no write", r_wr, 32'd0);
        chk("R5 leaf kept", mem[e2[15:2]], leaf);
    endtask

    // Permission fault: leaf allows everything except the chosen bits.
    task automatic t_prot(input logic [1:0] acc, input logic r, input logic w, input logic x);
        logic [31:0] e1, e2, leaf;
        lat = 2; base_addr = 32'h0;
        e1 = {18'b0, 12'd6, 2'b0};
        e2 = {22'h2C, 10'b0} + {20'b0, 10'd17, 2'b0};
        mem[e1[15:2]] = mk_pte(22'h2C, 1, 0, 0, 0, 0, 0);
        leaf = mk_pte(22'h1234, 1, r, w, x, 0, 0);
        mem[e2[15:2]] = leaf;
        run_walk(mk_va(12'd6, 10'd17, 10'h2A), acc, 0);
        chk("R6 fault", {31'b0, r_fault}, 32'd1);
        chk("R6 code", {30'b0, r_code}, 32'd3);
        chk("R6 no write", r_wr, 32'd0);
        chk("R6 leaf kept", mem[e2[15:2]], leaf);
    endtask

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = '0;
        for (int i = 0; i < 64; i++) rd_log[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R7 read with referenced clear: write-back sets bit 4.
        t_ok(32'h0, 12'd1, 10'd5, 10'h155, 22'h20, 22'h12345, 2'd0, 0, 0, 0, 0);
        // R7 read with referenced already set: no write.
        t_ok(32'h0, 12'd1, 10'd6, 10'h001, 22'h20, 22'h3ABCD, 2'd0, 1, 0, 1, 0);
        // R7 write with ref set, dirty clear: write-back sets dirty (R8 latency 3).
        t_ok(32'h0, 12'd3, 10'd1023, 10'h3FF, 22'h30, 22'h0F0F0, 2'd1, 1, 0, 3, 0);
        // R7 write with both flags set: no write.
        t_ok(32'h0, 12'd3, 10'd7, 10'h200, 22'h30, 22'h00001, 2'd1, 1, 1, 0, 0);
        // Execute access, nonzero base (R1).
        t_ok(32'h2000, 12'd7, 10'd0, 10'h000, 22'h38, 22'h2FFFF, 2'd2, 0, 1, 1, 0);
        t_l1_absent();
        t_l2_absent();
        t_prot(2'd1, 1, 0, 1);
        t_prot(2'd2, 1, 1, 0);
        t_prot(2'd0, 0, 1, 1);
        t_prot(2'd3, 1, 1, 1);
        // R9 second request during a slow walk is ignored.
        t_ok(32'h0, 12'd1, 10'd40, 10'h0AB, 22'h20, 22'h15555, 2'd0, 0, 0, 4, 1);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual expired expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule